// File: doc/BRIEF.md
# Unsigned Subtractor with Sign and Magnitude Output

This block takes two unsigned operands of a common, parameterised width and reports their difference as a magnitude plus a separate minus flag. It has no subtractor of its own. The subtrahend is inverted and fed to a ripple-carry adder with a carry-in of one, so the adder produces the minuend plus the two's complement of the subtrahend.

The carry leaving the top bit of that adder picks the sign. A carry means the minuend is not below the subtrahend; the carry is dropped and the adder result is already the answer. No carry means the true difference is negative. A conditional negation stage then takes the two's complement of the adder result, so the reported magnitude is always the absolute difference.

The block is purely combinational, with no clock, reset or state. A small package holds the two sign codes. The decode is a two-way choice on the end carry: code `SIGN_POS` passes the adder result through, and code `SIGN_NEG` negates it and raises the flag. The negation stage keeps every bit up to and including the lowest set bit and inverts every bit above it. As a result, a zero input stays zero and the output always fits the operand width.

Top module: `usub_signmag`

## Requirements
- R1: `neg` is 1 exactly when `op_m` is less than `op_n` as unsigned integers, and 0 otherwise.
- R2: When `op_m` is greater than `op_n`, `mag` equals `op_m - op_n`.
- R3: When `op_m` is less than `op_n`, `mag` equals `op_n - op_m`, which is the two's complement of the adder's raw sum.
- R4: When `op_m` equals `op_n`, including both zero, `mag` is 0 and `neg` is 0.
- R5: At the range extremes, all ones minus zero gives `mag` all ones with `neg` 0, and zero minus all ones gives `mag` all ones with `neg` 1.
- R6: `mag` is never zero while `neg` is 1.
- R7: The outputs are a pure function of the present inputs: they follow an input change without any clock edge.
- R8: R1 to R6 hold for any `WIDTH` of 2 or more, and in particular for 4 and for the default of 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_m | input | WIDTH | Minuend, unsigned |
| op_n | input | WIDTH | Subtrahend, unsigned |
| mag | output | WIDTH | Absolute value of op_m minus op_n |
| neg | output | 1 | Set when op_m is less than op_n |

## Verification
The embedded immediate checks assume that both operands are fully known two-state values and that they have settled before the outputs are judged. The adder identity and the negation identity are only meaningful on settled, defined bits. The bench therefore changes the operands only at a falling clock edge and inspects the outputs a nanosecond later. It never drives unknown values, and it sweeps every operand pair for a 4-bit and an 8-bit instance.

// File: rtl/usub_pkg.sv
package usub_pkg;

    // Sign decision taken from the end carry of the adder.
    typedef enum logic {
        SIGN_POS = 1'b0,
        SIGN_NEG = 1'b1
    } sign_e;

endpackage

// File: rtl/usub_fulladd.sv
module usub_fulladd (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);

    logic half_s;
    logic half_c;
    logic top_c;

    // First half adder on the two operand bits.
    always_comb begin
        half_s = a ^ b;
        half_c = a & b;
    end

    // Second half adder adds the incoming carry; its carry is ORed with the first.
    always_comb begin
        s     = half_s ^ ci;
        top_c = half_s & ci;
        co    = half_c | top_c;
    end

endmodule

// File: rtl/usub_ripple.sv
module usub_ripple #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             ci,
    output logic [WIDTH-1:0] sum,
    output logic             co
);

    localparam int CHAIN = WIDTH + 1;

    logic [CHAIN-1:0] carry;

    assign carry[0] = ci;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            usub_fulladd u_fa (
                .a  (a[i]),
                .b  (b[i]),
                .ci (carry[i]),
                .s  (sum[i]),
                .co (carry[i+1])
            );
        end
    endgenerate

    assign co = carry[WIDTH];

    // The bit-level carry chain must agree with integer addition (R1 relies on the end carry).
    logic [WIDTH:0] ref_total;
    always_comb begin
        ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, ci};
        p_chain_sum_r1: assert ({co, sum} == ref_total);
    end

endmodule

// File: rtl/usub_cond_negate.sv
module usub_cond_negate #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic             en,
    output logic [WIDTH-1:0] y
);

    // seen[i] is set when any bit below position i is 1.
    logic [WIDTH:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_scan
            assign seen[i+1] = seen[i] | x[i];
            // Bits above the lowest 1 are inverted; the rest pass through.
            assign y[i] = x[i] ^ (en & seen[i]);
        end
    endgenerate

    logic [WIDTH-1:0] wrap_sum;
    always_comb begin
        wrap_sum = x + y;
        if (!en) begin
            p_pass_through_r2: assert (y == x);
        end
        if (en) begin
            p_negate_wraps_r3: assert (wrap_sum == '0);
        end
        if (x == '0) begin
            p_zero_kept_r4: assert (y == '0);
        end
    end

endmodule

// File: rtl/usub_signmag.sv
module usub_signmag
    import usub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] op_m,
    input  logic [WIDTH-1:0] op_n,
    output logic [WIDTH-1:0] mag,
    output logic             neg
);

    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    logic [WIDTH-1:0] n_inv;
    logic [WIDTH-1:0] raw_sum;
    logic             end_carry;
    sign_e            res_sign;
    logic             do_negate;

    // Ones' complement of the subtrahend; the +1 arrives as the adder carry-in.
    assign n_inv = ~op_n;

    usub_ripple #(
        .WIDTH (WIDTH)
    ) u_add (
        .a   (op_m),
        .b   (n_inv),
        .ci  (1'b1),
        .sum (raw_sum),
        .co  (end_carry)
    );

    // Sign decode from the end carry.
    always_comb begin
        res_sign  = end_carry ? SIGN_POS : SIGN_NEG;
        do_negate = 1'b0;
        unique case (res_sign)
            SIGN_POS: do_negate = 1'b0;
            SIGN_NEG: do_negate = 1'b1;
        endcase
    end

    usub_cond_negate #(
        .WIDTH (WIDTH)
    ) u_fix (
        .x  (raw_sum),
        .en (do_negate),
        .y  (mag)
    );

    assign neg = do_negate;

    always_comb begin
        p_sign_order_r1: assert (neg == (op_m < op_n));
        if (neg) begin
            p_no_neg_zero_r6: assert (mag != '0);
        end
        if (op_m == op_n) begin
            p_equal_zero_r4: assert (mag == '0 && !neg);
        end
        if (op_m == ALL_ONES && op_n == '0) begin
            p_top_extreme_r5: assert (mag == ALL_ONES && !neg);
        end
    end

endmodule

// File: tb/usub_signmag_bench.sv
module usub_signmag_bench;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [7:0] m8 = '0;
    logic [7:0] n8 = '0;
    logic [7:0] mag8;
    logic       neg8;
    logic [3:0] m4 = '0;
    logic [3:0] n4 = '0;
    logic [3:0] mag4;
    logic       neg4;

    usub_signmag #(.WIDTH(8)) u_usub_signmag (
        .op_m (m8), .op_n (n8), .mag (mag8), .neg (neg8)
    );

    usub_signmag #(.WIDTH(4)) u_usub_signmag_w4 (
        .op_m (m4), .op_n (n4), .mag (mag4), .neg (neg4)
    );

    always @(posedge clk) cycles++;

    function automatic string pick_tag(int w, int m, int n);
        int top = (1 << w) - 1;
        if ((m == top && n == 0) || (m == 0 && n == top)) return "R5";
        if (m == n) return "R4";
        if (m > n) return "R2";
        return "R3";
    endfunction

    // One check of mag/neg (R1 sign, R8 width) plus R6 when the result is negative.
    task automatic check_pair(int w, int m, int n, int got_mag, bit got_neg);
        int exp_mag = (m >= n) ? (m - n) : (n - m);
        bit exp_neg = (m < n);
        string tag  = pick_tag(w, m, n);
        checks++;
        if (got_mag != exp_mag || got_neg != exp_neg) begin
            errors++;
            $display("FAIL %s (R1 sign, R8 w=%0d) m=%0d n=%0d: mag=%0d neg=%0b expected mag=%0d neg=%0b",
                     tag, w, m, n, got_mag, got_neg, exp_mag, exp_neg);
        end
        if (exp_neg) begin
            checks++;
            if (got_neg && got_mag == 0) begin
                errors++;
                $display("FAIL R6 w=%0d m=%0d n=%0d: mag=%0d expected nonzero", w, m, n, got_mag);
            end
        end
    endtask

    initial begin
        // Initial operands are zero: both instances must read 0, positive (R4).
        #1;
        check_pair(8, 0, 0, mag8, neg8);
        check_pair(4, 0, 0, mag4, neg4);

        // R7: a change settles with no clock edge in between.
        m8 = 8'd19; n8 = 8'd30;
        #1;
        check_pair(8, 19, 30, mag8, neg8);
        m8 = 8'd255; n8 = 8'd0;
        #1;
        check_pair(8, 255, 0, mag8, neg8);

        // Exhaustive 4-bit sweep (R8).
        for (int m = 0; m < 16; m++) begin
            for (int n = 0; n < 16; n++) begin
                @(negedge clk);
                m4 = 4'(m); n4 = 4'(n);
                #1;
                check_pair(4, m, n, mag4, neg4);
            end
        end

        // Exhaustive 8-bit sweep: every ordering, equal pair and extreme.
        for (int m = 0; m < 256; m++) begin
            for (int n = 0; n < 256; n++) begin
                @(negedge clk);
                m8 = 8'(m); n8 = 8'(n);
                #1;
                check_pair(8, m, n, mag8, neg8);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles >= 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: cycles=%0d expected completion below 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule